// File: doc/BRIEF.md
# Write Buffer with Read Bypass

This block sits between a cache and the next memory level and holds writes that are on their way out: write-through stores, and dirty lines displaced by a fill. Writes are posted into a small FIFO and leave through a single memory request port whenever that port is free. A read miss does not wait for the FIFO to empty. Its line address is first compared with every occupied slot. If no slot matches, the read is granted the memory port ahead of all queued writes. Only a write already presented on the port is allowed to finish first.

A matching read is handled by one of two policies, chosen by a parameter. In forwarding mode, the newest buffered copy of the line is returned straight from the buffer. In ordered mode, the read is held while writes drain in FIFO order. It goes to memory once no slot matches any more.

A read miss may carry a displaced dirty line. That line enters the buffer in the same cycle the read is accepted. The read is performed first, and the requester gets its data before the displaced line is written to memory.

Top module: `wbuf_bypass`

## Requirements
- R1: After reset the buffer is empty: `wr_ready` and `rd_ready` are high, and `mem_req_valid` and `rd_resp_valid` are low.
- R2: A read address is compared with every occupied slot, including the most recently written one. A read that matches no slot returns the memory contents of its address.
- R3: A read that matches no slot is the next request issued on the memory port after the write already presented there (if any), ahead of every other queued write.
- R4: The buffer holds `DEPTH` lines. While it is full, `wr_ready` is low and a write offered on the write port is not taken.
- R5: When no read is being accepted, buffered writes are issued to memory one at a time, in the order they were enqueued.
- R6: In forwarding mode (`FORWARD`=1), a read that matches returns the data of the newest matching slot, with `rd_resp_valid` high in the cycle after acceptance, and it issues no memory read.
- R7: Two buffered writes to the same address reach memory in enqueue order, so memory ends with the later data.
- R8: A read accepted with `rd_evict` high places (`ev_addr`, `ev_data`) in the buffer in the acceptance cycle. The memory read is issued before that line's write. The read data is returned before the line is written to memory.
- R9: In ordered mode (`FORWARD`=0), a matching read is not accepted until writes up to and including the newest matching slot have been issued. The read is then sent to memory and returns the written data.
- R10: Once `mem_req_valid` is high, the request and its address, data and direction stay unchanged until `mem_req_ready` is seen.
- R11: `rd_resp_valid` is a single-cycle pulse for each accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write offered for buffering |
| wr_ready | output | 1 | Buffer can take a write this cycle |
| wr_addr | input | ADDR_W | Line address of the write |
| wr_data | input | LINE_W | Line data of the write |
| rd_valid | input | 1 | Read miss request |
| rd_ready | output | 1 | Read accepted this cycle |
| rd_addr | input | ADDR_W | Line address of the read |
| rd_evict | input | 1 | Read displaces a dirty line |
| ev_addr | input | ADDR_W | Address of the displaced line |
| ev_data | input | LINE_W | Data of the displaced line |
| rd_resp_valid | output | 1 | Read data valid pulse |
| rd_resp_data | output | LINE_W | Read data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Memory request address |
| mem_req_wdata | output | LINE_W | Memory write data |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | LINE_W | Memory read data |

## Verification
The hardest situation to reach is a read that arrives while several writes are still queued and one of them is already on the memory port. Without stalling, the buffer drains faster than the bench can fill it. The bench therefore holds the memory model's ready low while it fills the buffer, raises the read, and only then releases the stall. This gives exact control over which slots are occupied when the address compare happens. The same stall is used to place a match in the newest slot after the pointers have wrapped, and to offer a write to a full buffer. A memory model logs the order of all requests, so the bench can tell whether the read overtook the queued writes.

// File: rtl/wbb_pkg.sv
package wbb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WRITE,
      ST_RDREQ,
      ST_RDWAIT
   } wbb_state_e;

endpackage

// File: rtl/wbb_fifo.sv
module wbb_fifo #(
   parameter int AW    = 16,
   parameter int DW    = 64,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   input  logic [AW-1:0] look_addr,
   output logic          full,
   output logic          empty,
   output logic [AW-1:0] head_addr,
   output logic [DW-1:0] head_data,
   output logic          hit,
   output logic [DW-1:0] hit_data
);

   localparam int PW = $clog2(DEPTH);
   localparam int CW = PW + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("wbb_fifo: DEPTH must be a power of two of at least 2");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("wbb_fifo: widths must be positive");
   end

   logic [AW-1:0] addr_q [DEPTH];
   logic [DW-1:0] data_q [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         cnt <= cnt + CW'(push) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         addr_q[wr_ptr] <= push_addr;
         data_q[wr_ptr] <= push_data;
      end
   end

   assign full      = (cnt == CW'(DEPTH));
   assign empty     = (cnt == '0);
   assign head_addr = addr_q[rd_ptr];
   assign head_data = data_q[rd_ptr];

   // per-slot age (distance from head) and live compare
   logic [PW-1:0]    age      [DEPTH];
   logic [DEPTH-1:0] slot_hit;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      assign age[g]      = PW'(g) - rd_ptr;
      assign slot_hit[g] = ({1'b0, age[g]} < cnt) && (addr_q[g] == look_addr);
   end

   // newest match = largest age among hits
   logic [PW-1:0] best_age;
   always_comb begin
      hit      = 1'b0;
      hit_data = '0;
      best_age = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (slot_hit[i] && (!hit || age[i] > best_age)) begin
            hit      = 1'b1;
            best_age = age[i];
            hit_data = data_q[i];
         end
      end
   end

   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && full));

   a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop && empty));

endmodule

// File: rtl/wbb_ctrl.sv
module wbb_ctrl
   import wbb_pkg::*;
#(
   parameter int AW      = 16,
   parameter int DW      = 64,
   parameter int FORWARD = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_valid,
   input  logic          rd_evict,
   input  logic [AW-1:0] rd_addr,
   output logic          rd_ready,
   output logic          rd_resp_valid,
   output logic [DW-1:0] rd_resp_data,
   input  logic          hit,
   input  logic [DW-1:0] hit_data,
   input  logic          full,
   input  logic          empty,
   input  logic [AW-1:0] head_addr,
   input  logic [DW-1:0] head_data,
   output logic          pop,
   output logic          evict_push,
   output logic          mem_req_valid,
   input  logic          mem_req_ready,
   output logic          mem_req_we,
   output logic [AW-1:0] mem_req_addr,
   output logic [DW-1:0] mem_req_wdata,
   input  logic          mem_rsp_valid,
   input  logic [DW-1:0] mem_rsp_data
);

   if (FORWARD != 0 && FORWARD != 1) begin : g_bad_mode
      $error("wbb_ctrl: FORWARD must be 0 or 1");
   end

   logic use_fwd, hold_rd;

   if (FORWARD == 1) begin : g_forward
      assign use_fwd = hit;
      assign hold_rd = 1'b0;
   end else begin : g_ordered
      assign use_fwd = 1'b0;
      assign hold_rd = hit;
   end

   wbb_state_e    st_q, st_d;
   logic [AW-1:0] rd_addr_q;
   logic          resp_v_q;
   logic [DW-1:0] resp_d_q;
   logic          rd_go;

   assign rd_ready   = (st_q == ST_IDLE) && !hold_rd && !(rd_evict && full);
   assign rd_go      = rd_valid && rd_ready;
   assign evict_push = rd_go && rd_evict;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: begin
            if (rd_go)       st_d = use_fwd ? ST_IDLE : ST_RDREQ;
            else if (!empty) st_d = ST_WRITE;
         end
         ST_WRITE:  if (mem_req_ready) st_d = ST_IDLE;
         ST_RDREQ:  if (mem_req_ready) st_d = ST_RDWAIT;
         ST_RDWAIT: if (mem_rsp_valid) st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         resp_v_q  <= 1'b0;
         resp_d_q  <= '0;
         rd_addr_q <= '0;
      end else begin
         st_q     <= st_d;
         resp_v_q <= (rd_go && use_fwd) || (st_q == ST_RDWAIT && mem_rsp_valid);
         if (rd_go) rd_addr_q <= rd_addr;
         if (rd_go && use_fwd)                    resp_d_q <= hit_data;
         else if (st_q == ST_RDWAIT && mem_rsp_valid) resp_d_q <= mem_rsp_data;
      end
   end

   assign mem_req_valid = (st_q == ST_WRITE) || (st_q == ST_RDREQ);
   assign mem_req_we    = (st_q == ST_WRITE);
   assign mem_req_addr  = (st_q == ST_WRITE) ? head_addr : rd_addr_q;
   assign mem_req_wdata = head_data;
   assign pop           = (st_q == ST_WRITE) && mem_req_ready;
   assign rd_resp_valid = resp_v_q;
   assign rd_resp_data  = resp_d_q;

   a_r10_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr)
          && (!mem_req_we || $stable(mem_req_wdata))));

   a_r11_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rd_resp_valid |=> !rd_resp_valid);

   a_r3_read_next: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && !use_fwd) |=> (mem_req_valid && !mem_req_we));

   a_r8_evict_room: assert property (@(posedge clk) disable iff (!rst_n)
      evict_push |-> !full);

endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass #(
   parameter int ADDR_W  = 16,
   parameter int LINE_W  = 64,
   parameter int DEPTH   = 4,
   parameter int FORWARD = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [LINE_W-1:0] wr_data,
   input  logic              rd_valid,
   output logic              rd_ready,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_evict,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic [LINE_W-1:0] ev_data,
   output logic              rd_resp_valid,
   output logic [LINE_W-1:0] rd_resp_data,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_we,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [LINE_W-1:0] mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [LINE_W-1:0] mem_rsp_data
);

   logic              full, empty, hit, pop, evict_push, push;
   logic [ADDR_W-1:0] head_addr, push_addr;
   logic [LINE_W-1:0] head_data, hit_data, push_data;

   // eviction takes the single enqueue slot in its cycle
   assign wr_ready  = !full && !evict_push;
   assign push      = evict_push || (wr_valid && wr_ready);
   assign push_addr = evict_push ? ev_addr : wr_addr;
   assign push_data = evict_push ? ev_data : wr_data;

   wbb_fifo #(.AW(ADDR_W), .DW(LINE_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_addr (push_addr),
      .push_data (push_data),
      .pop       (pop),
      .look_addr (rd_addr),
      .full      (full),
      .empty     (empty),
      .head_addr (head_addr),
      .head_data (head_data),
      .hit       (hit),
      .hit_data  (hit_data)
   );

   wbb_ctrl #(.AW(ADDR_W), .DW(LINE_W), .FORWARD(FORWARD)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .rd_valid      (rd_valid),
      .rd_evict      (rd_evict),
      .rd_addr       (rd_addr),
      .rd_ready      (rd_ready),
      .rd_resp_valid (rd_resp_valid),
      .rd_resp_data  (rd_resp_data),
      .hit           (hit),
      .hit_data      (hit_data),
      .full          (full),
      .empty         (empty),
      .head_addr     (head_addr),
      .head_data     (head_data),
      .pop           (pop),
      .evict_push    (evict_push),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_we    (mem_req_we),
      .mem_req_addr  (mem_req_addr),
      .mem_req_wdata (mem_req_wdata),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data)
   );

   a_r4_ready_low_full: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !wr_ready);

endmodule

// File: tb/wbb_mem_model.sv
module wbb_mem_model #(
   parameter int AW = 16,
   parameter int DW = 64
) (
   input  logic          clk,
   input  logic          stall,
   input  logic          req_valid,
   input  logic          req_we,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          req_ready,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data
);

   logic [DW-1:0] mem  [256];
   logic [AW-1:0] wlog [64];
   int            wcnt, rcnt, rd_at;
   logic          pend, dly;
   logic [DW-1:0] pdata;

   function automatic logic [DW-1:0] seed(input logic [7:0] a);
      return DW'({8{a}} ^ 64'h0F1E_2D3C_4B5A_6978);
   endfunction

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = seed(8'(i));
      wcnt = 0; rcnt = 0; rd_at = 0; pend = 1'b0; dly = 1'b0; pdata = '0;
   end

   assign req_ready = !stall;
   assign rsp_valid = pend && !dly;
   assign rsp_data  = pdata;

   always @(posedge clk) begin
      if (pend) begin
         if (dly) dly <= 1'b0;
         else     pend <= 1'b0;
      end
      if (req_valid && req_ready) begin
         if (req_we) begin
            mem[req_addr[7:0]] <= req_wdata;
            wlog[wcnt[5:0]]    <= req_addr;
            wcnt               <= wcnt + 1;
         end else begin
            pdata <= mem[req_addr[7:0]];
            pend  <= 1'b1;
            dly   <= 1'b1;
            rd_at <= wcnt;
            rcnt  <= rcnt + 1;
         end
      end
   end

endmodule

// File: tb/wbuf_bypass_test.sv
module wbuf_bypass_test;

   localparam int AW = 16;
   localparam int DW = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int checks = 0;
   int fails  = 0;

   // shared stimulus buses, per-instance valids selected by sel
   logic          sel = 1'b0;
   logic          stall = 1'b0;
   logic          wr_valid = 1'b0, rd_valid = 1'b0, rd_evict = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0, ev_addr = '0;
   logic [DW-1:0] wr_data = '0, ev_data = '0;

   logic          wr_ready_f, rd_ready_f, resp_v_f, mreq_v_f, mreq_we_f, mrdy_f, mrsp_v_f;
   logic [AW-1:0] mreq_a_f;
   logic [DW-1:0] resp_d_f, mreq_d_f, mrsp_d_f;
   logic          wr_ready_o, rd_ready_o, resp_v_o, mreq_v_o, mreq_we_o, mrdy_o, mrsp_v_o;
   logic [AW-1:0] mreq_a_o;
   logic [DW-1:0] resp_d_o, mreq_d_o, mrsp_d_o;

   wbuf_bypass #(.ADDR_W(AW), .LINE_W(DW), .DEPTH(4), .FORWARD(1)) uut (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid && !sel), .wr_ready(wr_ready_f), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_valid(rd_valid && !sel), .rd_ready(rd_ready_f), .rd_addr(rd_addr),
      .rd_evict(rd_evict), .ev_addr(ev_addr), .ev_data(ev_data),
      .rd_resp_valid(resp_v_f), .rd_resp_data(resp_d_f),
      .mem_req_valid(mreq_v_f), .mem_req_ready(mrdy_f), .mem_req_we(mreq_we_f),
      .mem_req_addr(mreq_a_f), .mem_req_wdata(mreq_d_f),
      .mem_rsp_valid(mrsp_v_f), .mem_rsp_data(mrsp_d_f));

   wbuf_bypass #(.ADDR_W(AW), .LINE_W(DW), .DEPTH(4), .FORWARD(0)) uut_ord (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid && sel), .wr_ready(wr_ready_o), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_valid(rd_valid && sel), .rd_ready(rd_ready_o), .rd_addr(rd_addr),
      .rd_evict(rd_evict), .ev_addr(ev_addr), .ev_data(ev_data),
      .rd_resp_valid(resp_v_o), .rd_resp_data(resp_d_o),
      .mem_req_valid(mreq_v_o), .mem_req_ready(mrdy_o), .mem_req_we(mreq_we_o),
      .mem_req_addr(mreq_a_o), .mem_req_wdata(mreq_d_o),
      .mem_rsp_valid(mrsp_v_o), .mem_rsp_data(mrsp_d_o));

   wbb_mem_model #(.AW(AW), .DW(DW)) m_f (
      .clk(clk), .stall(stall), .req_valid(mreq_v_f), .req_we(mreq_we_f),
      .req_addr(mreq_a_f), .req_wdata(mreq_d_f), .req_ready(mrdy_f),
      .rsp_valid(mrsp_v_f), .rsp_data(mrsp_d_f));

   wbb_mem_model #(.AW(AW), .DW(DW)) m_o (
      .clk(clk), .stall(stall), .req_valid(mreq_v_o), .req_we(mreq_we_o),
      .req_addr(mreq_a_o), .req_wdata(mreq_d_o), .req_ready(mrdy_o),
      .rsp_valid(mrsp_v_o), .rsp_data(mrsp_d_o));

   wire          wr_ready_s = sel ? wr_ready_o : wr_ready_f;
   wire          rd_ready_s = sel ? rd_ready_o : rd_ready_f;
   wire          resp_v_s   = sel ? resp_v_o   : resp_v_f;
   wire [DW-1:0] resp_d_s   = sel ? resp_d_o   : resp_d_f;
   wire [AW-1:0] mreq_a_s   = sel ? mreq_a_o   : mreq_a_f;
   wire          mreq_v_s   = sel ? mreq_v_o   : mreq_v_f;

   function automatic logic [DW-1:0] seed(input logic [7:0] a);
      return DW'({8{a}} ^ 64'h0F1E_2D3C_4B5A_6978);
   endfunction
   function automatic logic [DW-1:0] pat(input int n);
      return {32'hC0DE_0000 + 32'(n), 32'h1234_5678 ^ 32'(n * 7)};
   endfunction

   function automatic int mw();
      return sel ? m_o.wcnt : m_f.wcnt;
   endfunction
   function automatic int mr();
      return sel ? m_o.rcnt : m_f.rcnt;
   endfunction
   function automatic int mrd_at();
      return sel ? m_o.rd_at : m_f.rd_at;
   endfunction
   function automatic logic [AW-1:0] mlog(input int i);
      return sel ? m_o.wlog[i[5:0]] : m_f.wlog[i[5:0]];
   endfunction
   function automatic logic [DW-1:0] mmem(input int a);
      return sel ? m_o.mem[a[7:0]] : m_f.mem[a[7:0]];
   endfunction

   task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all tasks start and end at a negedge
   task automatic push(input int a, input logic [DW-1:0] d);
      int g = 0;
      wr_addr = AW'(a); wr_data = d; wr_valid = 1'b1;
      while (!wr_ready_s && g < 100) begin @(negedge clk); g++; end
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic rd_issue(input int a, input bit ev, input int ea, input logic [DW-1:0] ed);
      int g = 0;
      rd_addr = AW'(a); rd_evict = ev; ev_addr = AW'(ea); ev_data = ed; rd_valid = 1'b1;
      while (!rd_ready_s && g < 100) begin @(negedge clk); g++; end
      @(negedge clk);
      rd_valid = 1'b0; rd_evict = 1'b0;
   endtask

   task automatic rd_wait(output logic [DW-1:0] d, output int lat);
      lat = 0;
      while (!resp_v_s && lat < 200) begin @(negedge clk); lat++; end
      d = resp_d_s;
   endtask

   task automatic wait_writes(input int n);
      int g = 0;
      while (mw() < n && g < 200) begin @(negedge clk); g++; end
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      check(wr_ready_f == 1'b1, "R1 wr_ready", DW'(wr_ready_f), 1);
      check(rd_ready_f == 1'b1, "R1 rd_ready", DW'(rd_ready_f), 1);
      check(mreq_v_f == 1'b0, "R1 mem_req_valid", DW'(mreq_v_f), 0);
      check(resp_v_f == 1'b0, "R1 rd_resp_valid", DW'(resp_v_f), 0);
   endtask

   // R3 R5 R10 R2: read overtakes queued writes
   task automatic t_bypass();
      logic [DW-1:0] d;
      int lat, w0;
      sel = 1'b0; w0 = mw(); stall = 1'b1;
      for (int i = 0; i < 4; i++) push(10 + i, pat(10 + i));
      check(mreq_v_s && mreq_a_s == AW'(10), "R10 request presented", DW'(mreq_a_s), 10);
      @(negedge clk);
      check(mreq_v_s && mreq_a_s == AW'(10), "R10 request held", DW'(mreq_a_s), 10);
      stall = 1'b0;
      rd_issue(40, 1'b0, 0, '0);
      rd_wait(d, lat);
      check(d == seed(8'd40), "R2 miss returns memory data", d, seed(8'd40));
      check(mrd_at() - w0 == 1, "R3 read ahead of queued writes", DW'(mrd_at() - w0), 1);
      wait_writes(w0 + 4);
      for (int i = 0; i < 4; i++)
         check(mlog(w0 + i) == AW'(10 + i), "R5 FIFO drain order", DW'(mlog(w0 + i)), DW'(10 + i));
   endtask

   // R4: write offered while full is not taken
   task automatic t_full();
      int w0;
      sel = 1'b0; w0 = mw(); stall = 1'b1;
      for (int i = 0; i < 4; i++) push(70 + i, pat(70 + i));
      check(wr_ready_s == 1'b0, "R4 wr_ready low when full", DW'(wr_ready_s), 0);
      wr_addr = AW'(74); wr_data = pat(74); wr_valid = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0;
      stall = 1'b0;
      wait_writes(w0 + 4);
      repeat (6) @(negedge clk);
      check(mw() == w0 + 4, "R4 write count while full", DW'(mw() - w0), 4);
      check(mmem(74) == seed(8'd74), "R4 dropped write untouched", mmem(74), seed(8'd74));
   endtask

   // R6 R7: newest matching slot forwarded
   task automatic t_forward();
      logic [DW-1:0] d;
      int lat, w0, r0;
      sel = 1'b0; w0 = mw(); r0 = mr(); stall = 1'b1;
      push(22, pat(1));
      push(20, pat(2));
      push(20, pat(3));
      push(21, pat(4));
      stall = 1'b0;
      rd_issue(20, 1'b0, 0, '0);
      rd_wait(d, lat);
      check(lat == 0, "R6 response cycle after accept", DW'(lat), 0);
      check(d == pat(3), "R6 newest matching data", d, pat(3));
      check(mr() == r0, "R6 no memory read", DW'(mr() - r0), 0);
      wait_writes(w0 + 4);
      check(mmem(20) == pat(3), "R7 later same-address write wins", mmem(20), pat(3));
   endtask

   // R2: match in newest slot after wrap
   task automatic t_match_tail();
      logic [DW-1:0] d;
      int lat, w0, r0;
      sel = 1'b0; w0 = mw(); r0 = mr(); stall = 1'b1;
      for (int i = 0; i < 4; i++) push(80 + i, pat(80 + i));
      stall = 1'b0;
      rd_issue(83, 1'b0, 0, '0);
      rd_wait(d, lat);
      check(d == pat(83), "R2 match in newest slot", d, pat(83));
      check(mr() == r0, "R2 no memory read on match", DW'(mr() - r0), 0);
      wait_writes(w0 + 4);
   endtask

   // R8 R11: dirty eviction with a read miss
   task automatic t_evict();
      logic [DW-1:0] d;
      int lat, w0;
      sel = 1'b0; stall = 1'b0; w0 = mw();
      rd_issue(50, 1'b1, 60, pat(60));
      rd_wait(d, lat);
      check(d == seed(8'd50), "R8 read data", d, seed(8'd50));
      check(mw() == w0, "R8 data returned before evicted write", DW'(mw() - w0), 0);
      check(mrd_at() == w0, "R8 read issued before evicted write", DW'(mrd_at() - w0), 0);
      @(negedge clk);
      check(resp_v_s == 1'b0, "R11 single-cycle response", DW'(resp_v_s), 0);
      wait_writes(w0 + 1);
      check(mlog(w0) == AW'(60), "R8 evicted line address", DW'(mlog(w0)), 60);
      check(mmem(60) == pat(60), "R8 evicted line data", mmem(60), pat(60));
   endtask

   // R9: ordered mode drains through the match
   task automatic t_ordered();
      logic [DW-1:0] d;
      int lat, w0;
      sel = 1'b1; w0 = mw(); stall = 1'b1;
      push(30, pat(30));
      push(31, pat(31));
      push(32, pat(32));
      stall = 1'b0;
      rd_issue(31, 1'b0, 0, '0);
      rd_wait(d, lat);
      check(d == pat(31), "R9 read returns written data", d, pat(31));
      check(mrd_at() - w0 == 2, "R9 writes through match before read", DW'(mrd_at() - w0), 2);
      wait_writes(w0 + 3);
      sel = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bypass();
      t_full();
      t_forward();
      t_match_tail();
      t_evict();
      t_ordered();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule